// File: doc/BRIEF.md
# GMII Receive Frame Gate and Address Filter

This block sits directly behind a gigabit media-independent receive port and decides which received bytes travel onward to a buffer. It registers the line signals once. It opens a capture window on the first cycle the data-valid line is high. It discards the preamble until the start-of-frame delimiter byte appears, then forwards every following byte, the frame check sequence included, on a byte stream.

While bytes flow, the block accumulates a CRC-32 over the forwarded bytes and records the first six of them as the destination address. When the valid line drops it issues exactly one verdict pulse. A frame is reported good only if all of these hold:
- the CRC register equals the fixed residue;
- no line error was seen;
- no byte was lost downstream;
- the address filter accepts the destination.

A good verdict also publishes the payload length, which is the count of forwarded bytes minus the four check bytes. A downstream buffer writes every forwarded byte and commits or rewinds when the verdict arrives.

The output stream cannot apply back-pressure to the line. `out_ready` is the downstream "room left" indication. A byte presented with `out_ready` low is lost, and the rest of that frame is abandoned.

Top module: `gmii_rx_gate`

## Requirements
- R1: Capture opens on the very first cycle `gm_valid` is high, so a delimiter byte 0xD5 on that first cycle is recognised; any number of 0x55 preamble bytes (including none) before 0xD5 gives the same result.
- R2: Bytes up to and including the first 0xD5 of a frame are never forwarded. Every later byte is forwarded in arrival order, including the four check bytes. A frame that never carries 0xD5 forwards nothing and raises no event.
- R3: The CRC-32 (reflected polynomial 0xEDB88320, preset all ones, bytes fed LSB first) over all forwarded bytes must equal the residue 0xDEBB20E3 with at least four bytes forwarded. Otherwise a clean frame ends with `ev_crc_err` and never with `ev_frame_ok`.
- R4: `frame_bytes` resets to 0. It changes only in the cycle `ev_frame_ok` is high, and then equals the number of forwarded bytes minus 4.
- R5: A clean frame with a good CRC raises `ev_frame_ok` when any of these holds: `cfg_take_all`; the destination is FF:FF:FF:FF:FF:FF and `cfg_take_bcast`; the first destination octet is 0x01 and `cfg_take_mcast`; the destination equals `cfg_station` (bits 47:40 are the first octet) and `cfg_take_ucast`. Otherwise the frame ends silently.
- R6: `gm_error` high while `gm_valid` is high stops forwarding from that byte on. The frame ends with `ev_phy_err` and neither `ev_frame_ok` nor `ev_crc_err`.
- R7: A byte shown with `out_valid` high and `out_ready` low is lost. No further byte of that frame is forwarded, and the frame ends with `ev_overflow` and without `ev_frame_ok`.
- R8: Each event is a single-cycle pulse. It is visible two clock edges after the edge that first samples `gm_valid` low.
- R9: A forwarded byte appears on `out_data` with `out_valid` two clock edges after it is sampled on `gm_data`.
- R10: Frames separated by a single idle cycle are both captured and judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gm_valid | input | 1 | Line data valid |
| gm_data | input | 8 | Line data byte |
| gm_error | input | 1 | Line error indication |
| cfg_take_all | input | 1 | Accept every destination |
| cfg_take_bcast | input | 1 | Accept the broadcast destination |
| cfg_take_mcast | input | 1 | Accept destinations whose first octet is 0x01 |
| cfg_take_ucast | input | 1 | Accept the station's own destination |
| cfg_station | input | 48 | Station address, first octet in bits 47:40 |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_ready | input | 1 | Downstream has room; low while `out_valid` loses the byte |
| ev_frame_ok | output | 1 | Good, accepted frame pulse |
| ev_crc_err | output | 1 | CRC residue mismatch pulse |
| ev_phy_err | output | 1 | Line error in frame pulse |
| ev_overflow | output | 1 | Byte lost downstream pulse |
| frame_bytes | output | LEN_W | Length of the last good frame, check bytes excluded |

## Verification
Payload lengths and preamble lengths are swept with correct check bytes. This separates correct delimiter hunting and byte counting from off-by-one errors at the first capture cycle. A single flipped bit is walked across every byte of a frame, which shows that every position feeds the CRC and that no check byte is skipped. Four destination kinds are crossed with all sixteen filter settings, giving the full acceptance table. Line errors and downstream stalls are walked across every byte index, which pins down how many bytes escape before the abort. A pair of frames with one idle cycle between them exercises re-arming of the capture window.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
  localparam int          FCS_BYTES   = 4;
  localparam int          ADDR_BYTES  = 6;

  // one byte of reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxg_capture_gate.sv
module rxg_capture_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dv_i,
  input  logic err_i,
  input  logic ovf_i,
  output logic start_o,
  output logic cap_o,
  output logic dv_prev_o
);
  logic hold_q;
  logic clr;

  assign start_o = dv_i & ~dv_prev_o;
  assign clr     = ~dv_i | err_i | ovf_i;
  assign cap_o   = hold_q | start_o;

  // set/reset flag, clear dominates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_prev_o <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      dv_prev_o <= dv_i;
      if (clr)          hold_q <= 1'b0;
      else if (start_o) hold_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxg_crc32.sv
module rxg_crc32
  import rxg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_o <= CRC_PRESET;
    else if (init_i) crc_o <= CRC_PRESET;
    else if (en_i)   crc_o <= crc32_step(crc_o, data_i);
  end
endmodule

// File: rtl/rxg_addr_filter.sv
module rxg_addr_filter
  import rxg_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  input  logic [47:0]      station_i,
  input  logic             take_all_i,
  input  logic             take_bcast_i,
  input  logic             take_mcast_i,
  input  logic             take_ucast_i,
  output logic             pass_o
);
  logic [7:0]            dst [ADDR_BYTES];
  logic [ADDR_BYTES-1:0] oct_ff;
  logic [ADDR_BYTES-1:0] oct_me;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_oct
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 dst[g] <= 8'h00;
      else if (clear_i)                           dst[g] <= 8'h00;
      else if (en_i && idx_i == IDX_W'(g))        dst[g] <= data_i;
    end
    assign oct_ff[g] = (dst[g] == 8'hFF);
    assign oct_me[g] = (dst[g] == station_i[47-8*g -: 8]);
  end

  logic is_bcast, is_mcast, is_mine;
  assign is_bcast = &oct_ff;
  assign is_mcast = (dst[0] == 8'h01);
  assign is_mine  = &oct_me;

  assign pass_o = take_all_i
                | (is_bcast & take_bcast_i)
                | (is_mcast & take_mcast_i)
                | (is_mine  & take_ucast_i);
endmodule

// File: rtl/gmii_rx_gate.sv
module gmii_rx_gate
  import rxg_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gm_valid,
  input  logic [7:0]       gm_data,
  input  logic             gm_error,
  input  logic             cfg_take_all,
  input  logic             cfg_take_bcast,
  input  logic             cfg_take_mcast,
  input  logic             cfg_take_ucast,
  input  logic [47:0]      cfg_station,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             ev_frame_ok,
  output logic             ev_crc_err,
  output logic             ev_phy_err,
  output logic             ev_overflow,
  output logic [LEN_W-1:0] frame_bytes
);
  localparam logic [LEN_W-1:0] CNT_MAX    = '1;
  localparam logic [LEN_W-1:0] MIN_STORED = LEN_W'(FCS_BYTES);

  // line registers
  logic       s_dv, s_er;
  logic [7:0] s_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_dv <= 1'b0;
      s_er <= 1'b0;
      s_d  <= 8'h00;
    end else begin
      s_dv <= gm_valid;
      s_er <= gm_error;
      s_d  <= gm_data;
    end
  end

  logic stall_hit;
  assign stall_hit = out_valid & ~out_ready;

  logic frm_start, cap_en, dv_prev;
  rxg_capture_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .dv_i      (s_dv),
    .err_i     (s_er),
    .ovf_i     (stall_hit),
    .start_o   (frm_start),
    .cap_o     (cap_en),
    .dv_prev_o (dv_prev)
  );

  logic             hunt_q, hunting, byte_ok, sfd_hit, store, frm_end;
  logic [LEN_W-1:0] byte_cnt;
  logic             er_seen, ovf_seen;

  assign hunting = frm_start | hunt_q;
  assign byte_ok = cap_en & s_dv & ~s_er & ~stall_hit;
  assign sfd_hit = byte_ok & hunting & (s_d == SFD_BYTE);
  assign store   = byte_ok & ~hunting;
  assign frm_end = dv_prev & ~s_dv;

  logic [31:0] crc_val;
  rxg_crc32 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (frm_start),
    .en_i   (store),
    .data_i (s_d),
    .crc_o  (crc_val)
  );

  logic addr_pass;
  rxg_addr_filter #(.IDX_W(LEN_W)) u_filt (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (frm_start),
    .en_i         (store),
    .idx_i        (byte_cnt),
    .data_i       (s_d),
    .station_i    (cfg_station),
    .take_all_i   (cfg_take_all),
    .take_bcast_i (cfg_take_bcast),
    .take_mcast_i (cfg_take_mcast),
    .take_ucast_i (cfg_take_ucast),
    .pass_o       (addr_pass)
  );

  // per-frame tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_q   <= 1'b1;
      byte_cnt <= '0;
      er_seen  <= 1'b0;
      ovf_seen <= 1'b0;
    end else begin
      if (sfd_hit)        hunt_q <= 1'b0;
      else if (frm_start) hunt_q <= 1'b1;

      if (frm_start)                        byte_cnt <= '0;
      else if (store && byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;

      if (frm_start)          er_seen <= s_er;
      else if (s_dv && s_er)  er_seen <= 1'b1;

      if (frm_start)      ovf_seen <= 1'b0;
      else if (stall_hit) ovf_seen <= 1'b1;
    end
  end

  logic ovf_any, clean, crc_good;
  assign ovf_any  = ovf_seen | stall_hit;
  assign clean    = ~er_seen & ~ovf_any & ~hunt_q;
  assign crc_good = (crc_val == CRC_RESIDUE) && (byte_cnt >= MIN_STORED);

  // output stream and verdicts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= 8'h00;
      ev_frame_ok <= 1'b0;
      ev_crc_err  <= 1'b0;
      ev_phy_err  <= 1'b0;
      ev_overflow <= 1'b0;
      frame_bytes <= '0;
    end else begin
      out_valid <= store;
      if (store) out_data <= s_d;
      ev_phy_err  <= frm_end & er_seen;
      ev_overflow <= frm_end & ovf_any;
      ev_crc_err  <= frm_end & clean & ~crc_good;
      ev_frame_ok <= frm_end & clean & crc_good & addr_pass;
      if (frm_end && clean && crc_good && addr_pass)
        frame_bytes <= byte_cnt - MIN_STORED;
    end
  end
endmodule

// File: rtl/gmii_rx_gate_chk.sv
module gmii_rx_gate_chk #(
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gm_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic             ev_frame_ok,
  input logic             ev_crc_err,
  input logic             ev_phy_err,
  input logic             ev_overflow,
  input logic [LEN_W-1:0] frame_bytes
);
  logic any_ev;
  assign any_ev = ev_frame_ok | ev_crc_err | ev_phy_err | ev_overflow;

  // R9
  fwd_after_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(gm_valid, 2));

  // R7
  stall_ends_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !out_valid);

  // R3
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_ok |-> !(ev_crc_err || ev_phy_err || ev_overflow));

  // R4
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_frame_ok |-> $stable(frame_bytes));

  // R8
  ev_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> !any_ev);

  // R8
  ev_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |-> !$past(gm_valid, 2));
endmodule

bind gmii_rx_gate gmii_rx_gate_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gm_valid    (gm_valid),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .ev_frame_ok (ev_frame_ok),
  .ev_crc_err  (ev_crc_err),
  .ev_phy_err  (ev_phy_err),
  .ev_overflow (ev_overflow),
  .frame_bytes (frame_bytes)
);

// File: tb/gmii_rx_gate_tb_top.sv
module gmii_rx_gate_tb_top;
  localparam int LEN_W = 14;
  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic gm_valid = 1'b0, gm_error = 1'b0;
  logic [7:0] gm_data = 8'h00;
  logic cfg_take_all = 1'b0, cfg_take_bcast = 1'b1, cfg_take_mcast = 1'b1, cfg_take_ucast = 1'b1;
  logic out_ready = 1'b1;
  logic out_valid, ev_frame_ok, ev_crc_err, ev_phy_err, ev_overflow;
  logic [7:0] out_data;
  logic [LEN_W-1:0] frame_bytes;

  gmii_rx_gate #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .gm_valid(gm_valid), .gm_data(gm_data), .gm_error(gm_error),
    .cfg_take_all(cfg_take_all), .cfg_take_bcast(cfg_take_bcast),
    .cfg_take_mcast(cfg_take_mcast), .cfg_take_ucast(cfg_take_ucast),
    .cfg_station(STATION), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .ev_frame_ok(ev_frame_ok), .ev_crc_err(ev_crc_err), .ev_phy_err(ev_phy_err),
    .ev_overflow(ev_overflow), .frame_bytes(frame_bytes));

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // frame under test
  logic [7:0] fr [0:255];
  int fr_len = 0;

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic build(input logic [47:0] dst, input int pay);
    logic [31:0] c;
    for (int i = 0; i < 6; i++) fr[i] = dst[47-8*i -: 8];
    for (int i = 0; i < 6; i++) fr[6+i] = 8'(8'h20 + i);
    fr[12] = 8'h08; fr[13] = 8'h00;
    for (int i = 0; i < pay; i++) fr[14+i] = 8'(i*7 + 3);
    fr_len = 14 + pay;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < fr_len; i++) c = ref_crc(c, fr[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) fr[fr_len+i] = c[8*i +: 8];
    fr_len += 4;
  endtask

  // monitor
  logic [7:0] got [0:511];
  int n_got = 0, n_ok = 0, n_crc = 0, n_phy = 0, n_ovf = 0;
  int stall_at = -1, t_first = 0, t_got0 = 0, t_end = 0, t_ok = 0;
  int last_len = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      if (stall_at == n_got) begin
        out_ready = 1'b0;
        stall_at = -1;
      end else begin
        out_ready = 1'b1;
        if (n_got == 0) t_got0 = cyc;
        if (n_got < 512) got[n_got] = out_data;
        n_got++;
      end
    end else out_ready = 1'b1;
    if (ev_frame_ok) begin n_ok++; last_len = int'(frame_bytes); t_ok = cyc; end
    if (ev_crc_err)  n_crc++;
    if (ev_phy_err)  n_phy++;
    if (ev_overflow) n_ovf++;
  end

  task automatic clear_mon();
    n_got = 0; n_ok = 0; n_crc = 0; n_phy = 0; n_ovf = 0;
  endtask

  task automatic send(input int pre, input bit sfd, input int er_at, input int gap);
    for (int i = 0; i < pre; i++) begin
      @(negedge clk); gm_valid = 1'b1; gm_data = 8'h55; gm_error = 1'b0;
    end
    if (sfd) begin
      @(negedge clk); gm_valid = 1'b1; gm_data = 8'hD5; gm_error = 1'b0;
    end
    for (int i = 0; i < fr_len; i++) begin
      @(negedge clk); gm_valid = 1'b1; gm_data = fr[i]; gm_error = (i == er_at);
      if (i == 0) t_first = cyc;
    end
    @(negedge clk); gm_valid = 1'b0; gm_data = 8'h00; gm_error = 1'b0; t_end = cyc;
    for (int i = 1; i < gap; i++) @(negedge clk);
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < fr_len; i++) if (got[i] !== fr[i]) m++;
    return m;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset length", int'(frame_bytes), 0);
    chk("R2 reset stream idle", int'(out_valid), 0);
    chk("R8 reset events idle", int'(ev_frame_ok | ev_crc_err | ev_phy_err | ev_overflow), 0);

    // R2 R3 R4: payload length sweep, good frames to own address
    for (int p = 0; p <= 20; p++) begin
      build(STATION, p); clear_mon(); send(7, 1'b1, -1, 6);
      chk("R3 good frame accepted", n_ok, 1);
      chk("R3 no crc error", n_crc, 0);
      chk("R2 forwarded count", n_got, fr_len);
      chk("R2 forwarded bytes", mism(), 0);
      chk("R4 reported length", last_len, fr_len - 4);
      if (p == 0) begin
        chk("R9 forward latency", t_got0 - t_first, 2);
        chk("R8 verdict latency", t_ok - t_end, 2);
      end
    end

    // R1: preamble length sweep including delimiter on first cycle
    for (int pre = 0; pre <= 7; pre++) begin
      build(STATION, 4); clear_mon(); send(pre, 1'b1, -1, 6);
      chk("R1 accepted for preamble", n_ok, 1);
      chk("R1 forwarded count", n_got, fr_len);
      chk("R1 forwarded bytes", mism(), 0);
    end

    // R2: frame without delimiter
    fr_len = 0; clear_mon(); send(30, 1'b0, -1, 6);
    chk("R2 no delimiter nothing forwarded", n_got, 0);
    chk("R2 no delimiter no event", n_ok + n_crc + n_phy + n_ovf, 0);

    // R3: single bit flip walked over every byte
    build(STATION, 10);
    for (int pos = 0; pos < fr_len; pos++) begin
      fr[pos] ^= 8'h10; clear_mon(); send(7, 1'b1, -1, 6);
      chk("R3 corrupted gives crc error", n_crc, 1);
      chk("R3 corrupted not accepted", n_ok, 0);
      fr[pos] ^= 8'h10;
    end

    // R5: destination kind x filter settings
    for (int dt = 0; dt < 4; dt++) begin
      for (int cf = 0; cf < 16; cf++) begin
        logic [47:0] d;
        int exp;
        case (dt)
          0: d = 48'hFF_FF_FF_FF_FF_FF;
          1: d = 48'h01_00_5E_00_00_FB;
          2: d = STATION;
          default: d = STATION ^ 48'h1;
        endcase
        {cfg_take_all, cfg_take_bcast, cfg_take_mcast, cfg_take_ucast} = 4'(cf);
        exp = (cf[3] || (dt == 0 && cf[2]) || (dt == 1 && cf[1]) || (dt == 2 && cf[0])) ? 1 : 0;
        build(d, 3); clear_mon(); send(7, 1'b1, -1, 6);
        chk("R5 filter verdict", n_ok, exp);
        chk("R5 filtered frame no crc error", n_crc, 0);
      end
    end
    {cfg_take_all, cfg_take_bcast, cfg_take_mcast, cfg_take_ucast} = 4'b0111;

    // R6: line error at every byte index
    build(STATION, 6);
    for (int k = 0; k < fr_len; k++) begin
      clear_mon(); send(7, 1'b1, k, 6);
      chk("R6 phy error event", n_phy, 1);
      chk("R6 not accepted", n_ok + n_crc, 0);
      chk("R6 bytes before error", n_got, k);
    end

    // R7: downstream stall at every byte index
    for (int k = 0; k < fr_len; k++) begin
      clear_mon(); stall_at = k; send(7, 1'b1, -1, 6);
      chk("R7 overflow event", n_ovf, 1);
      chk("R7 not accepted", n_ok, 0);
      chk("R7 bytes before stall", n_got, k);
    end
    stall_at = -1;

    // R10: two frames one idle cycle apart
    build(STATION, 2); clear_mon();
    send(3, 1'b1, -1, 1);
    send(3, 1'b1, -1, 6);
    chk("R10 both frames accepted", n_ok, 2);
    chk("R10 both frames forwarded", n_got, 2 * fr_len);
    chk("R10 no errors", n_crc + n_phy + n_ovf, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule